// File: doc/BRIEF.md
# Dual-Slope Phase-Correct PWM Timer

This block is a 16-bit timer that counts up and down, producing a symmetric triangle between zero (BOTTOM) and a selectable TOP. Two compare channels watch the counter. Each one drives a PWM output that changes state on the way up and again on the way down, so both edges of the pulse sit symmetrically around BOTTOM. The counter moves only in cycles where the timer clock enable `tick` is high. A prescaler that generates `tick` lies outside the block.

A mode code chooses the source of TOP: a fixed 8-, 9- or 10-bit ceiling, a separately written TOP register, or compare register A. Writes to the compare registers land in a buffer, and the buffer is copied into the active compare value only when the counter is at TOP. As a result, a duty-cycle change never breaks the symmetry of the period in progress. Four sticky status flags report BOTTOM, a match on each channel and TOP. Each flag is cleared by a write-one strobe.

Top module: `pcpwm_timer`

## Requirements
- R1: After reset the counter is 0 and counting up. On each cycle with `tick` high it moves one step toward its turning point, so it counts 0,1,...,TOP,TOP-1,...,0,1,... and holds every value, TOP and 0 included, for exactly one tick. With `tick` low it holds.
- R2: The `mode` code selects TOP. The code values are 1 for 0x00FF, 2 for 0x01FF, 3 for 0x03FF, 10 for the TOP register and 11 for the active compare A value. Any other code freezes the counter.
- R3: Compare writes go to a buffer. The active compare value takes the buffered value only on the tick in which the counter is at TOP while counting up. Until then the old active value governs matches. After reset both values are 0.
- R4: `ovf_flag` is set on the tick in which the counter sits at 0 while counting down, which is the turn at BOTTOM.
- R5: In mode 10 `top_flag` is set, and in mode 11 `cmpa_flag` is set, on the same tick at TOP in which the buffers are loaded.
- R6: A channel's flag is set on every tick in which the counter equals that channel's active compare value. A compare value above TOP never matches.
- R7: In modes 1, 2 and 3, a compare value that is written keeps only its low 8, 9 or 10 bits, and the bits above are stored as zero.
- R8: Output mode `om_x` = 2 is non-inverted: a match while counting up drives the output low, and a match while counting down drives it high. Output mode 3 is the reverse. Output modes 0 and 1 hold the output low. Matches are evaluated against the counter value and direction before the step.
- R9: Flags are sticky. Bit order of `flag_clr` is 0 for overflow, 1 for compare A, 2 for compare B and 3 for TOP. A 1 clears the flag on the next edge, and a set event in the same cycle wins over the clear. All flags are 0 after reset.
- R10: A TOP register value as small as 3 gives a correct triangle of period 6 ticks with working compare outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timer clock enable |
| mode | input | 4 | TOP source select |
| top_we | input | 1 | TOP register write strobe |
| top_wdata | input | 16 | TOP register write data |
| cmpa_we | input | 1 | Compare A buffer write strobe |
| cmpa_wdata | input | 16 | Compare A write data |
| cmpb_we | input | 1 | Compare B buffer write strobe |
| cmpb_wdata | input | 16 | Compare B write data |
| om_a | input | 2 | Output mode, channel A |
| om_b | input | 2 | Output mode, channel B |
| flag_clr | input | 4 | Write-one-to-clear strobes for the flags |
| count | output | 16 | Current counter value |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |
| ovf_flag | output | 1 | BOTTOM reached |
| cmpa_flag | output | 1 | Compare A match |
| cmpb_flag | output | 1 | Compare B match |
| top_flag | output | 1 | TOP reached in TOP-register mode |

## Verification
A scoreboard compares every cycle of the counter and both outputs in the three fixed modes, against the minimum TOP of 3 and with `tick` gated every other cycle. A design that turned one tick early or late at TOP or BOTTOM would drift out of phase, and one that loaded compare values at once instead of at TOP would toggle its outputs in the first half period. Written values carry high bits above the fixed resolution, so a missing mask would move or suppress the pulse edges. Targeted checks place a clear strobe on the exact tick of a TOP event, where a design that let the clear win would drop the flag. Other targeted checks hold a compare value above TOP, where any spurious match would raise a flag. Mode 11 must turn at compare A and flag it.

// File: rtl/pcpwm_pkg.sv
`timescale 1ns/1ps
// Shared codes and helpers for the phase-correct PWM timer.
// Assumes the counter width is at least 10 bits so all fixed TOP values fit.
package pcpwm_pkg;

    typedef logic [3:0] mode_t;

    // TOP source codes
    localparam mode_t MODE_FIX8   = 4'd1;
    localparam mode_t MODE_FIX9   = 4'd2;
    localparam mode_t MODE_FIX10  = 4'd3;
    localparam mode_t MODE_TOPREG = 4'd10;
    localparam mode_t MODE_CMPA   = 4'd11;

    // Output mode codes
    localparam logic [1:0] OM_NONINV = 2'd2;
    localparam logic [1:0] OM_INV    = 2'd3;

    // Flag bit positions (also the clear strobe positions)
    localparam int FLG_OVF   = 0;
    localparam int FLG_CMPA  = 1;
    localparam int FLG_CMPB  = 2;
    localparam int FLG_TOP   = 3;
    localparam int NUM_FLAGS = 4;

    // Resolution of a fixed-TOP mode in bits; 0 means not a fixed mode.
    function automatic int fixed_bits(mode_t m);
        case (m)
            MODE_FIX8:  return 8;
            MODE_FIX9:  return 9;
            MODE_FIX10: return 10;
            default:    return 0;
        endcase
    endfunction

    // True for the mode codes in which the counter runs.
    function automatic logic mode_runs(mode_t m);
        return (m == MODE_FIX8) || (m == MODE_FIX9) || (m == MODE_FIX10) ||
               (m == MODE_TOPREG) || (m == MODE_CMPA);
    endfunction

endpackage

// File: rtl/pcpwm_topsel.sv
`timescale 1ns/1ps
// TOP source selection and compare write mask.
// Purely combinational. For fixed modes TOP equals the write mask
// (2^bits - 1); other running modes take TOP from a register value.
// Assumes CW >= 10.
module pcpwm_topsel
    import pcpwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  mode_t          mode,
    input  logic [CW-1:0]  top_reg,
    input  logic [CW-1:0]  cmpa_act,
    output logic [CW-1:0]  top_val,
    output logic [CW-1:0]  wmask,
    output logic           mode_ok
);

    // Build the write mask from the fixed resolution of the mode.
    always_comb begin
        int bits;
        bits = fixed_bits(mode);
        for (int i = 0; i < CW; i++) begin
            wmask[i] = (bits == 0) || (i < bits);
        end
    end

    // Choose the TOP value for the current mode.
    always_comb begin
        case (mode)
            MODE_FIX8, MODE_FIX9, MODE_FIX10: top_val = wmask;
            MODE_TOPREG:                      top_val = top_reg;
            MODE_CMPA:                        top_val = cmpa_act;
            default:                          top_val = '0;
        endcase
    end

    // Running modes.
    assign mode_ok = mode_runs(mode);

endmodule

// File: rtl/pcpwm_counter.sv
`timescale 1ns/1ps
// Dual-slope counter. Steps once per run cycle, turns down on the step
// taken at (or above) TOP and turns up on the step taken at zero, so both
// extremes are held for exactly one tick. at_top and at_bottom mark the
// run cycle in which the counter sits at a turning point.
// Assumes run is already gated by a valid mode.
module pcpwm_counter #(
    parameter int CW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic [CW-1:0]  top_val,
    output logic [CW-1:0]  cnt,
    output logic           dir_up,
    output logic           at_top,
    output logic           at_bottom
);

    localparam logic [CW-1:0] ONE = CW'(1);

    assign at_top    = run && dir_up && (cnt >= top_val);
    assign at_bottom = run && !dir_up && (cnt == '0);

    // Advance the triangle and flip direction at the turning points.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            dir_up <= 1'b1;
        end else if (run) begin
            if (dir_up) begin
                if (cnt >= top_val) begin
                    dir_up <= 1'b0;
                    if (cnt != '0) cnt <= cnt - ONE;
                end else begin
                    cnt <= cnt + ONE;
                end
            end else begin
                if (cnt == '0) begin
                    dir_up <= 1'b1;
                    if (top_val != '0) cnt <= ONE;
                end else begin
                    cnt <= cnt - ONE;
                end
            end
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt)); // R1
    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && dir_up && cnt < top_val) |=> (cnt == $past(cnt) + ONE)); // R1
    AST_TOP_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (run && dir_up && cnt == top_val && cnt != '0) |=> (!dir_up && cnt == $past(cnt) - ONE)); // R1
    AST_BOTTOM_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        (at_bottom && top_val != '0) |=> (dir_up && cnt == ONE)); // R1

endmodule

// File: rtl/pcpwm_channel.sv
`timescale 1ns/1ps
// One compare channel: masked buffer write, load of the active value at
// TOP, match detection and the PWM output register.
// Assumes load is asserted only on the run cycle at TOP.
module pcpwm_channel
    import pcpwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [CW-1:0]  wr_data,
    input  logic [CW-1:0]  wr_mask,
    input  logic           load,
    input  logic           run,
    input  logic [CW-1:0]  cnt,
    input  logic           dir_up,
    input  logic [1:0]     omode,
    output logic [CW-1:0]  cmp_act,
    output logic           match,
    output logic           pwm
);

    logic [CW-1:0] cmp_buf;

    assign match = run && (cnt == cmp_act);

    // Capture a write into the buffer with unused high bits removed.
    always_ff @(posedge clk) begin
        if (!rst_n)     cmp_buf <= '0;
        else if (wr_en) cmp_buf <= wr_data & wr_mask;
    end

    // Copy the buffer into the active compare value at TOP.
    always_ff @(posedge clk) begin
        if (!rst_n)    cmp_act <= '0;
        else if (load) cmp_act <= cmp_buf;
    end

    // Drive the output from the match direction and output mode.
    always_ff @(posedge clk) begin
        if (!rst_n)            pwm <= 1'b0;
        else if (!omode[1])    pwm <= 1'b0;
        else if (match)        pwm <= dir_up ? (omode == OM_INV) : (omode == OM_NONINV);
    end

    AST_ACT_ONLY_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cmp_act)); // R3
    AST_BUF_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((cmp_buf & ~$past(wr_mask)) == '0)); // R7
    AST_OUT_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !omode[1] |=> !pwm); // R8
    AST_PWM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (omode[1] && !match) |=> $stable(pwm)); // R8

endmodule

// File: rtl/pcpwm_flags.sv
`timescale 1ns/1ps
// Sticky status flags with write-one-to-clear; set beats clear.
module pcpwm_flags #(
    parameter int N = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  set,
    input  logic [N-1:0]  clr,
    output logic [N-1:0]  flags
);

    // Hold, clear on strobe, set on event.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr) | set;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set) |=> ((flags & $past(set)) == $past(set))); // R9
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & ~($past(flags) | $past(set))) == '0)); // R9
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr & ~set)) |=> ((flags & $past(clr & ~set)) == '0)); // R9

endmodule

// File: rtl/pcpwm_timer.sv
`timescale 1ns/1ps
// Phase-correct PWM timer top: TOP register, TOP selection, dual-slope
// counter, two compare channels and the status flags.
// Assumes tick is a one-cycle enable from an external prescaler.
module pcpwm_timer
    import pcpwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic [3:0]     mode,
    input  logic           top_we,
    input  logic [CW-1:0]  top_wdata,
    input  logic           cmpa_we,
    input  logic [CW-1:0]  cmpa_wdata,
    input  logic           cmpb_we,
    input  logic [CW-1:0]  cmpb_wdata,
    input  logic [1:0]     om_a,
    input  logic [1:0]     om_b,
    input  logic [3:0]     flag_clr,
    output logic [CW-1:0]  count,
    output logic           pwm_a,
    output logic           pwm_b,
    output logic           ovf_flag,
    output logic           cmpa_flag,
    output logic           cmpb_flag,
    output logic           top_flag
);

    localparam int NCH = 2;

    logic [CW-1:0]  top_reg;
    logic [CW-1:0]  top_val;
    logic [CW-1:0]  wmask;
    logic           mode_ok;
    logic           run;
    logic [CW-1:0]  cnt;
    logic           dir_up;
    logic           at_top;
    logic           at_bottom;

    logic [NCH-1:0] ch_we;
    logic [CW-1:0]  ch_wdata [NCH];
    logic [1:0]     ch_om    [NCH];
    logic [CW-1:0]  ch_act   [NCH];
    logic [NCH-1:0] ch_match;
    logic [NCH-1:0] ch_pwm;

    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_q;

    // Hold the TOP register, written directly (not buffered).
    always_ff @(posedge clk) begin
        if (!rst_n)      top_reg <= '0;
        else if (top_we) top_reg <= top_wdata;
    end

    pcpwm_topsel #(.CW(CW)) u_topsel (
        .mode     (mode),
        .top_reg  (top_reg),
        .cmpa_act (ch_act[0]),
        .top_val  (top_val),
        .wmask    (wmask),
        .mode_ok  (mode_ok)
    );

    assign run = tick && mode_ok;

    pcpwm_counter #(.CW(CW)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .top_val   (top_val),
        .cnt       (cnt),
        .dir_up    (dir_up),
        .at_top    (at_top),
        .at_bottom (at_bottom)
    );

    // Route each channel's write port and output mode.
    assign ch_we[0]    = cmpa_we;
    assign ch_we[1]    = cmpb_we;
    assign ch_wdata[0] = cmpa_wdata;
    assign ch_wdata[1] = cmpb_wdata;
    assign ch_om[0]    = om_a;
    assign ch_om[1]    = om_b;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pcpwm_channel #(.CW(CW)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (ch_we[g]),
            .wr_data (ch_wdata[g]),
            .wr_mask (wmask),
            .load    (at_top),
            .run     (run),
            .cnt     (cnt),
            .dir_up  (dir_up),
            .omode   (ch_om[g]),
            .cmp_act (ch_act[g]),
            .match   (ch_match[g]),
            .pwm     (ch_pwm[g])
        );
    end

    // Collect the flag set events.
    always_comb begin
        flag_set           = '0;
        flag_set[FLG_OVF]  = at_bottom;
        flag_set[FLG_CMPA] = ch_match[0] || ((mode == MODE_CMPA) && at_top);
        flag_set[FLG_CMPB] = ch_match[1];
        flag_set[FLG_TOP]  = (mode == MODE_TOPREG) && at_top;
    end

    pcpwm_flags #(.N(NUM_FLAGS)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   (flag_clr),
        .flags (flag_q)
    );

    assign count     = cnt;
    assign pwm_a     = ch_pwm[0];
    assign pwm_b     = ch_pwm[1];
    assign ovf_flag  = flag_q[FLG_OVF];
    assign cmpa_flag = flag_q[FLG_CMPA];
    assign cmpb_flag = flag_q[FLG_CMPB];
    assign top_flag  = flag_q[FLG_TOP];

    AST_OVF_AT_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
        at_bottom |=> ovf_flag); // R4
    AST_CMPA_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_CMPA) && at_top) |=> cmpa_flag); // R5
    AST_TOPFLAG_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_TOPREG) && at_top) |=> top_flag); // R5
    AST_A_ABOVE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt <= top_val && ch_act[0] > top_val) |-> !ch_match[0]); // R6
    AST_B_ABOVE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt <= top_val && ch_act[1] > top_val) |-> !ch_match[1]); // R6

endmodule

// File: tb/pcpwm_timer_tb.sv
`timescale 1ns/1ps
module pcpwm_timer_tb;
    import pcpwm_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [3:0]  mode = 4'd0;
    logic        top_we = 1'b0, cmpa_we = 1'b0, cmpb_we = 1'b0;
    logic [15:0] top_wdata = '0, cmpa_wdata = '0, cmpb_wdata = '0;
    logic [1:0]  om_a = 2'd0, om_b = 2'd0;
    logic [3:0]  flag_clr = 4'd0;
    logic [15:0] count;
    logic        pwm_a, pwm_b, ovf_flag, cmpa_flag, cmpb_flag, top_flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [15:0] c;
        logic        a;
        logic        b;
    } exp_t;
    exp_t sbq[$];

    pcpwm_timer #(.CW(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode),
        .top_we(top_we), .top_wdata(top_wdata),
        .cmpa_we(cmpa_we), .cmpa_wdata(cmpa_wdata),
        .cmpb_we(cmpb_we), .cmpb_wdata(cmpb_wdata),
        .om_a(om_a), .om_b(om_b), .flag_clr(flag_clr),
        .count(count), .pwm_a(pwm_a), .pwm_b(pwm_b),
        .ovf_flag(ovf_flag), .cmpa_flag(cmpa_flag),
        .cmpb_flag(cmpb_flag), .top_flag(top_flag)
    );

    always #10 clk = ~clk;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reset, then program mode, registers and output modes with tick low.
    task automatic setup(mode_t m, logic [15:0] tv, logic [15:0] ca, logic [15:0] cb,
                         logic [1:0] oa, logic [1:0] ob);
        tick = 0; flag_clr = 0; rst_n = 0;
        step(); step();
        rst_n = 1; mode = m; om_a = oa; om_b = ob;
        top_we = 1; top_wdata = tv;
        cmpa_we = 1; cmpa_wdata = ca;
        cmpb_we = 1; cmpb_wdata = cb;
        step();
        top_we = 0; cmpa_we = 0; cmpb_we = 0;
    endtask

    // Driver: expected triangle and outputs from R1, R3, R8, pushed per edge.
    task automatic run_sb(int t, logic [15:0] ca, logic [15:0] cb,
                          logic [1:0] oa, logic [1:0] ob, int n, bit gap);
        logic [15:0] rc = 0;
        bit up = 1;
        logic [15:0] aa = 0, ab = 0;
        bit pa = 0, pb = 0;
        exp_t e;
        for (int i = 0; i < n; i++) begin
            bit tk;
            tk = gap ? (i % 2 == 0) : 1'b1;
            tick = tk;
            if (tk) begin
                if (rc == aa && oa[1]) pa = up ? (oa == OM_INV) : (oa == OM_NONINV);
                if (rc == ab && ob[1]) pb = up ? (ob == OM_INV) : (ob == OM_NONINV);
                if (up && rc == 16'(t)) begin
                    aa = ca; ab = cb; rc = rc - 1; up = 0;
                end else if (up) rc = rc + 1;
                else if (rc == 0) begin rc = 1; up = 1; end
                else rc = rc - 1;
            end
            step();
            e.c = rc; e.a = pa; e.b = pb;
            sbq.push_back(e);
        end
        tick = 0;
        wait (sbq.size() == 0);
        step();
    endtask

    // Monitor: compare the design against queued expectations.
    initial begin
        forever begin
            @(negedge clk);
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                // R1 R2 R10: counter position
                chk(count == e.c, "R1", "count", count, e.c);
                // R8 with R3 and R7: outputs depend on buffered masked compares
                chk(pwm_a == e.a, "R8", "pwm_a", pwm_a, e.a);
                chk(pwm_b == e.b, "R8", "pwm_b", pwm_b, e.b);
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int mx;
        // Reset state: R1, R9
        setup(MODE_FIX8, 16'd0, 16'd0, 16'd0, 2'd2, 2'd2);
        #5;
        chk(count == 0, "R1", "reset count", count, 0);
        chk({pwm_a, pwm_b} == 0, "R8", "reset pwm", {pwm_a, pwm_b}, 0);
        chk({ovf_flag, cmpa_flag, cmpb_flag, top_flag} == 0, "R9", "reset flags",
            {ovf_flag, cmpa_flag, cmpb_flag, top_flag}, 0);

        // R2 R7 mode 1: high bits of 0x1064 dropped, acts as 100
        setup(MODE_FIX8, 16'd0, 16'h1064, 16'd200, 2'd2, 2'd3);
        run_sb(255, 16'h1064 & 16'h00FF, 16'd200, 2'd2, 2'd3, 1025, 0);
        // R2 mode 2, channel A off (R8)
        setup(MODE_FIX9, 16'd0, 16'd300, 16'h80FF, 2'd0, 2'd2);
        run_sb(511, 16'd300, 16'h80FF & 16'h01FF, 2'd0, 2'd2, 1100, 0);
        // R2 R7 mode 3
        setup(MODE_FIX10, 16'd0, 16'hFDF4, 16'd1000, 2'd3, 2'd2);
        run_sb(1023, 16'hFDF4 & 16'h03FF, 16'd1000, 2'd3, 2'd2, 2100, 0);
        // R10 minimum TOP 3, tick gated (R1)
        setup(MODE_TOPREG, 16'd3, 16'd1, 16'd2, 2'd3, 2'd2);
        run_sb(3, 16'd1, 16'd2, 2'd3, 2'd2, 80, 1);

        // Flag timing in mode 10, TOP 5, compare A 9 (above TOP), B 3
        setup(MODE_TOPREG, 16'd5, 16'd9, 16'd3, 2'd2, 2'd2);
        tick = 1;
        for (int e = 1; e <= 40; e++) begin
            flag_clr = (e == 7)  ? 4'b0110 :
                       (e == 12) ? 4'b0001 :
                       (e == 16 || e == 17) ? 4'b1000 : 4'b0000;
            step();
            if (e == 4)  chk(pwm_b == 0, "R3", "no match before load", pwm_b, 0);
            if (e == 5)  chk(count == 5 && top_flag == 0, "R5", "top flag before TOP", top_flag, 0);
            if (e == 6)  chk(top_flag == 1, "R5", "top flag at TOP", top_flag, 1);
            if (e == 6)  chk(count == 4, "R1", "one tick at TOP", count, 4);
            if (e == 7)  chk(cmpb_flag == 0, "R9", "cmpb cleared", cmpb_flag, 0);
            if (e == 8)  chk(cmpb_flag == 1, "R6", "cmpb match", cmpb_flag, 1);
            if (e == 8)  chk(pwm_b == 1, "R8", "set on down match", pwm_b, 1);
            if (e == 10) chk(count == 0 && ovf_flag == 0, "R4", "ovf before turn", ovf_flag, 0);
            if (e == 11) chk(ovf_flag == 1, "R4", "ovf at BOTTOM", ovf_flag, 1);
            if (e == 12) chk(ovf_flag == 0, "R9", "ovf cleared", ovf_flag, 0);
            if (e == 16) chk(top_flag == 1, "R9", "set wins over clear", top_flag, 1);
            if (e == 17) chk(top_flag == 0, "R9", "top cleared", top_flag, 0);
        end
        flag_clr = 0;
        chk(cmpa_flag == 0, "R6", "no match above TOP", cmpa_flag, 0);
        chk(pwm_a == 0, "R6", "pwm_a idle above TOP", pwm_a, 0);

        // Mode 11: TOP from compare A = 7
        setup(MODE_CMPA, 16'd0, 16'd7, 16'd0, 2'd0, 2'd0);
        tick = 1;
        for (int i = 0; i < 40; i++) step();
        mx = 0;
        for (int i = 0; i < 20; i++) begin
            step();
            if (int'(count) > mx) mx = int'(count);
        end
        chk(mx == 7, "R2", "mode 11 peak", mx, 7);
        chk(cmpa_flag == 1, "R5", "cmpa flag in mode 11", cmpa_flag, 1);
        while (count != 7) step();
        flag_clr = 4'b0010;
        step();
        chk(cmpa_flag == 1, "R5", "cmpa set at TOP beats clear", cmpa_flag, 1);
        step();
        flag_clr = 0;
        chk(cmpa_flag == 0, "R9", "cmpa cleared", cmpa_flag, 0);
        tick = 0;
        step();
        chk(count == 5, "R1", "hold without tick", count, 5);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule